// File: doc/BRIEF.md
# Parallel ROM Host Read Sequencer

This block sits on the host side of an asynchronous parallel mask ROM. It turns single read requests into the pin sequence the ROM expects: chip enable, output enable, address, a width-mode line, and a shared top data line. The shared line carries the lowest address bit in 8-bit mode and data bit 15 in 16-bit mode. Every analog timing limit of the ROM is held as a picosecond parameter. Each limit is turned into a cycle count by ceiling division by the clock period, plus a margin for input synchronisation, so the same RTL serves any clock rate.

After reset the sequencer keeps chip enable high for the mandatory power-up hold. It then accepts requests on a valid/ready handshake. A request carries a word address, a low byte-select bit and a width flag. For each request the sequencer drives the pins, waits out the access time, captures the bus, and returns the data with a one-cycle response pulse. It then waits out the output-disable time before it can start another read. When consecutive reads use the same width, chip enable stays low between them, but each read still waits the full access time.

Top module: `rom_rd_seq`

## Requirements
- R1: While reset is asserted, and for 51 clock cycles after it is released (ceil(200 ns / period) + 1 at the 4 ns default), `rom_ce_n` and `rom_oe_n` stay high, `req_ready` stays low and `rom_hi_oe` stays low. `req_ready` rises after the 51st rising edge that follows reset release.
- R2: `req_ready` is high only when the sequencer is idle. A request is taken on a rising edge where both `req_valid` and `req_ready` are high. `req_ready` then stays low for exactly 2 + ACC + DF cycles, which is 36 at the defaults.
- R3: In the cycle after a request is taken, `rom_addr`, `rom_wide` and the shared line carry the new request. From the next edge, `rom_ce_n` and `rom_oe_n` are low for ACC cycles. ACC is the larger of ceil(t_acc / period) + 1 and the output-enable count. t_acc is 100 ns with `FAST_SUPPLY` = 0 and 90 ns with `FAST_SUPPLY` = 1, so ACC is 26 at the defaults. The bus is sampled on the edge that closes this window.
- R4: `rsp_valid` is high for exactly one cycle, 1 + ACC rising edges after the accepting edge, and `rsp_data` is valid in that cycle.
- R5: In 16-bit mode (`req_wide` = 1), `rom_wide` is 1, `rom_hi_oe` is 0 during the read, and `rsp_data` equals all 16 lines of `rom_bus_i`.
- R6: In 8-bit mode (`req_wide` = 0), `rom_wide` is 0, `rom_hi_oe` is 1 and `rom_hi_o` equals `req_lsb` during the read. `rsp_data` is `{8'h00, rom_bus_i[7:0]}`.
- R7: `rom_oe_n` rises on the sampling edge. The sequencer then waits 1 + DF cycles (DF = ceil(25 ns / period) + 1 = 8) before it changes the drive on the shared line, so it never drives that line while the ROM may still be driving it.
- R8: If a read uses the same width as the previous read, `rom_ce_n` stays low across the gap between the two reads.
- R9: If a read changes the width, `rom_ce_n` is high in its setup cycle and goes low again when the access window opens.
- R10: `req_valid` is ignored while `req_ready` is low. Such a request produces no response and no pin activity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_addr | input | ADDR_W (21) | Word address of the read |
| req_lsb | input | 1 | Byte select, used in 8-bit mode only |
| req_wide | input | 1 | 1 = 16-bit read, 0 = 8-bit read |
| rsp_valid | output | 1 | One-cycle pulse: read data present |
| rsp_data | output | DATA_W (16) | Read data, zero-extended in 8-bit mode |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_addr | output | ADDR_W (21) | ROM address lines |
| rom_wide | output | 1 | ROM width-mode line (1 = 16-bit) |
| rom_hi_o | output | 1 | Value driven on the shared top line in 8-bit mode |
| rom_hi_oe | output | 1 | Drive enable for the shared top line |
| rom_bus_i | input | DATA_W (16) | ROM data lines as seen by the host |

## Verification
The bench's ROM model returns good data only when address, width and chip enable have been stable for 100 ns and output enable has been low for 25 ns. Otherwise it returns inverted data. A sequencer that samples even one cycle early therefore returns wrong words, not the right ones by luck.

The bench goes after four corner cases:
- **Width change right after a 16-bit read.** A shortened release wait would drive the shared line while the ROM model still holds it, and the bench reports that overlap.
- **Width changes in both directions.** These expose a chip enable that fails to cycle high.
- **Back-to-back reads of the same width.** These expose a chip enable that bounces when it should stay low.
- **A request held during the power-up hold and a junk request held during a busy read.** A sequencer that took either one would show ready, response timing and response counts that differ from the reference model.

// File: rtl/rom_rd_pkg.sv
`timescale 1ns/1ps
package rom_rd_pkg;

  typedef enum logic [2:0] {
    ST_PWR     = 3'd0,
    ST_IDLE    = 3'd1,
    ST_SETUP   = 3'd2,
    ST_ACCESS  = 3'd3,
    ST_SAMPLE  = 3'd4,
    ST_RELEASE = 3'd5
  } rd_state_e;

  // timing limit in ps -> clock cycles, rounded up, plus sync margin
  function automatic int unsigned ps_to_cyc(input int unsigned lim_ps,
                                            input int unsigned clk_ps,
                                            input int unsigned margin);
    return (lim_ps + clk_ps - 1) / clk_ps + margin;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rom_rd_timer.sv
`timescale 1ns/1ps
// Loadable down-counter; done while the count sits at zero.
module rom_rd_timer #(
  parameter int unsigned      CNT_W   = 6,
  parameter logic [CNT_W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= RST_VAL;
    end else if (ld) begin
      cnt <= ld_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/rom_rd_capture.sv
`timescale 1ns/1ps
// Samples the ROM bus, zero-extends narrow reads, emits a one-cycle pulse.
module rom_rd_capture #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic              cap_wide,
  input  logic [DATA_W-1:0] bus_i,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  localparam int unsigned HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] shaped;

  generate
    if (DATA_W > HALF_W) begin : g_ext
      assign shaped = cap_wide ? bus_i : {{(DATA_W-HALF_W){1'b0}}, bus_i[HALF_W-1:0]};
    end else begin : g_flat
      assign shaped = bus_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= cap;
      if (cap) begin
        rsp_data <= shaped;
      end
    end
  end

endmodule

// File: rtl/rom_rd_fsm.sv
`timescale 1ns/1ps
// Read sequencing: owns every ROM-side pin register and the handshake.
module rom_rd_fsm
  import rom_rd_pkg::*;
#(
  parameter int unsigned ADDR_W  = 21,
  parameter int unsigned CNT_W   = 6,
  parameter int unsigned ACC_CYC = 26,
  parameter int unsigned DF_CYC  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_lsb,
  input  logic              req_wide,
  output logic              req_ready,
  input  logic              tmr_done,
  output logic              tmr_ld,
  output logic [CNT_W-1:0]  tmr_val,
  output logic              cap,
  output logic              cap_wide,
  output logic              rom_ce_n,
  output logic              rom_oe_n,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              rom_wide,
  output logic              rom_hi_o,
  output logic              rom_hi_oe
);

  localparam logic [CNT_W-1:0] ACC_LD = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] DF_LD  = CNT_W'(DF_CYC - 1);

  rd_state_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_PWR;
      rom_ce_n  <= 1'b1;
      rom_oe_n  <= 1'b1;
      rom_addr  <= '0;
      rom_wide  <= 1'b1;
      rom_hi_o  <= 1'b0;
      rom_hi_oe <= 1'b0;
    end else begin
      case (st)
        ST_PWR: begin
          if (tmr_done) st <= ST_IDLE;
        end
        ST_IDLE: begin
          if (req_valid) begin
            rom_addr  <= req_addr;
            rom_wide  <= req_wide;
            rom_hi_o  <= req_lsb & ~req_wide;
            rom_hi_oe <= ~req_wide;
            // width switch: cycle chip enable through a setup cycle
            if (req_wide != rom_wide) rom_ce_n <= 1'b1;
            st <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          rom_ce_n <= 1'b0;
          rom_oe_n <= 1'b0;
          st       <= ST_ACCESS;
        end
        ST_ACCESS: begin
          if (tmr_done) begin
            rom_oe_n <= 1'b1;
            st       <= ST_SAMPLE;
          end
        end
        ST_SAMPLE: begin
          st <= ST_RELEASE;
        end
        ST_RELEASE: begin
          if (tmr_done) st <= ST_IDLE;
        end
        default: st <= ST_PWR;
      endcase
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign tmr_ld    = (st == ST_SETUP) || (st == ST_SAMPLE);
  assign tmr_val   = (st == ST_SETUP) ? ACC_LD : DF_LD;
  assign cap       = (st == ST_ACCESS) && tmr_done;
  assign cap_wide  = rom_wide;

endmodule

// File: rtl/rom_rd_seq.sv
`timescale 1ns/1ps
// Host-side read sequencer for an asynchronous parallel ROM.
module rom_rd_seq
  import rom_rd_pkg::*;
#(
  parameter int unsigned ADDR_W      = 21,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CLK_PS      = 4000,
  parameter bit          FAST_SUPPLY = 1'b0,
  parameter int unsigned T_ACC_SLOW  = 100000,
  parameter int unsigned T_ACC_FAST  = 90000,
  parameter int unsigned T_OE_PS     = 25000,
  parameter int unsigned T_DF_PS     = 25000,
  parameter int unsigned T_PWR_PS    = 200000,
  parameter int unsigned SYNC_MARGIN = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_lsb,
  input  logic              req_wide,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rom_ce_n,
  output logic              rom_oe_n,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              rom_wide,
  output logic              rom_hi_o,
  output logic              rom_hi_oe,
  input  logic [DATA_W-1:0] rom_bus_i
);

  localparam int unsigned ACC_PS  = FAST_SUPPLY ? T_ACC_FAST : T_ACC_SLOW;
  localparam int unsigned OE_CYC  = ps_to_cyc(T_OE_PS, CLK_PS, SYNC_MARGIN);
  localparam int unsigned ACC_CYC = max2(ps_to_cyc(ACC_PS, CLK_PS, SYNC_MARGIN), OE_CYC);
  localparam int unsigned DF_CYC  = ps_to_cyc(T_DF_PS, CLK_PS, SYNC_MARGIN);
  localparam int unsigned PWR_CYC = ps_to_cyc(T_PWR_PS, CLK_PS, SYNC_MARGIN);
  localparam int unsigned MAX_CYC = max2(max2(ACC_CYC, DF_CYC), PWR_CYC);
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic             tmr_ld;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_done;
  logic             cap;
  logic             cap_wide;

  rom_rd_timer #(
    .CNT_W  (CNT_W),
    .RST_VAL(CNT_W'(PWR_CYC - 1))
  ) u_timer (
    .clk   (clk),
    .rst   (rst),
    .ld    (tmr_ld),
    .ld_val(tmr_val),
    .done  (tmr_done)
  );

  rom_rd_fsm #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .ACC_CYC(ACC_CYC),
    .DF_CYC (DF_CYC)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_addr (req_addr),
    .req_lsb  (req_lsb),
    .req_wide (req_wide),
    .req_ready(req_ready),
    .tmr_done (tmr_done),
    .tmr_ld   (tmr_ld),
    .tmr_val  (tmr_val),
    .cap      (cap),
    .cap_wide (cap_wide),
    .rom_ce_n (rom_ce_n),
    .rom_oe_n (rom_oe_n),
    .rom_addr (rom_addr),
    .rom_wide (rom_wide),
    .rom_hi_o (rom_hi_o),
    .rom_hi_oe(rom_hi_oe)
  );

  rom_rd_capture #(
    .DATA_W(DATA_W)
  ) u_cap (
    .clk      (clk),
    .rst      (rst),
    .cap      (cap),
    .cap_wide (cap_wide),
    .bus_i    (rom_bus_i),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data)
  );

endmodule

// File: rtl/rom_rd_seq_chk.sv
`timescale 1ns/1ps
module rom_rd_seq_chk
  import rom_rd_pkg::*;
#(
  parameter int unsigned ADDR_W      = 21,
  parameter int unsigned CLK_PS      = 4000,
  parameter int unsigned T_PWR_PS    = 200000,
  parameter int unsigned SYNC_MARGIN = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rom_ce_n,
  input logic              rom_oe_n,
  input logic [ADDR_W-1:0] rom_addr,
  input logic              rom_wide,
  input logic              rom_hi_oe
);

  localparam int unsigned PWR_CYC = ps_to_cyc(T_PWR_PS, CLK_PS, SYNC_MARGIN);

  int unsigned since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= 0;
    else if (since_rst < PWR_CYC) since_rst <= since_rst + 1;
  end

  a_r1_ce_held_in_power_wait: assert property (@(posedge clk) disable iff (rst)
    (since_rst < PWR_CYC) |-> rom_ce_n);

  a_r1_no_ready_in_power_wait: assert property (@(posedge clk) disable iff (rst)
    (since_rst < PWR_CYC) |-> !req_ready);

  a_r2_ready_bus_quiet: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> rom_oe_n);

  a_r3_oe_needs_ce: assert property (@(posedge clk) disable iff (rst)
    !rom_oe_n |-> !rom_ce_n);

  a_r3_addr_stable_in_access: assert property (@(posedge clk) disable iff (rst)
    !rom_oe_n |=> (rom_oe_n || $stable(rom_addr)));

  a_r9_width_stable_in_access: assert property (@(posedge clk) disable iff (rst)
    !rom_oe_n |=> (rom_oe_n || $stable(rom_wide)));

  a_r4_rsp_single_cycle: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  a_r4_rsp_not_idle: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);

  a_r5_hi_released_wide: assert property (@(posedge clk) disable iff (rst)
    (rom_wide && !rom_oe_n) |-> !rom_hi_oe);

  a_r6_hi_driven_byte: assert property (@(posedge clk) disable iff (rst)
    (!rom_wide && !rom_oe_n) |-> rom_hi_oe);

endmodule

bind rom_rd_seq rom_rd_seq_chk #(
  .ADDR_W     (ADDR_W),
  .CLK_PS     (CLK_PS),
  .T_PWR_PS   (T_PWR_PS),
  .SYNC_MARGIN(SYNC_MARGIN)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .rom_ce_n (rom_ce_n),
  .rom_oe_n (rom_oe_n),
  .rom_addr (rom_addr),
  .rom_wide (rom_wide),
  .rom_hi_oe(rom_hi_oe)
);

// File: tb/tb_rom_rd_seq.sv
`timescale 1ns/1ps
module tb_rom_rd_seq;

  // Expected cycle counts at a 4 ns clock, from the requirements
  localparam int PWR = 51;  // R1
  localparam int ACC = 26;  // R3
  localparam int DF  = 8;   // R7

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [20:0] req_addr = '0;
  logic        req_lsb = 1'b0;
  logic        req_wide = 1'b1;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        rom_ce_n, rom_oe_n, rom_wide, rom_hi_o, rom_hi_oe;
  logic [20:0] rom_addr;
  logic [15:0] rom_bus = '0;

  int checks = 0;
  int fails  = 0;
  int naccept = 0;
  int nrsp = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  rom_rd_seq dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_lsb(req_lsb), .req_wide(req_wide),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n), .rom_addr(rom_addr),
    .rom_wide(rom_wide), .rom_hi_o(rom_hi_o), .rom_hi_oe(rom_hi_oe),
    .rom_bus_i(rom_bus)
  );

  function automatic logic [15:0] wfn(input logic [20:0] a);
    return a[15:0] ^ {a[4:0], a[20:10]} ^ 16'h5A3C;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- ROM model (timing-aware) ----------------
  realtime t_chg = 0.0, t_oe = 0.0, t_act = 0.0;
  bit      have_act = 1'b0;

  always @(rom_addr or rom_wide or rom_hi_o or rom_hi_oe or rom_ce_n) t_chg = $realtime;
  always @(negedge rom_oe_n) t_oe = $realtime;

  always begin
    #1;
    begin
      logic        l, ok;
      logic [15:0] w, v;
      if (!rom_ce_n && !rom_oe_n && rom_wide) begin
        t_act = $realtime;
        have_act = 1'b1;
      end
      l  = rom_hi_oe ? rom_hi_o : 1'b0;
      ok = !rom_ce_n && !rom_oe_n && ($realtime - t_chg >= 100.0) &&
           ($realtime - t_oe >= 25.0) && (rom_wide || rom_hi_oe);
      w  = wfn(rom_addr);
      v  = rom_wide ? w : {8'hDA, (l ? w[15:8] : w[7:0])};
      rom_bus = ok ? v : ~v;
    end
  end

  // ---------------- reference model ----------------
  int          busy = 0;
  int          rsp_in = -1;
  bit          m_ce = 1'b1, m_setup = 1'b0, m_wide = 1'b1, m_wide_v = 1'b0, pwr_phase = 1'b1;
  logic [20:0] m_addr = '0;
  logic        m_lsb = 1'b0;
  logic [15:0] m_data = '0;

  always @(posedge clk) begin
    if (rst) begin
      busy = PWR; rsp_in = -1; m_ce = 1'b1; m_setup = 1'b0; pwr_phase = 1'b1;
    end else begin
      if (rsp_in == 0) rsp_in = -1;
      else if (rsp_in > 0) rsp_in--;
      if (m_setup) begin m_ce = 1'b0; m_setup = 1'b0; end
      if (busy > 0) begin
        busy--;
        if (busy == 0) pwr_phase = 1'b0;
      end else if (req_valid) begin
        busy   = 2 + ACC + DF;
        rsp_in = 1 + ACC;
        if (m_wide_v && (req_wide != m_wide)) m_ce = 1'b1;
        m_wide = req_wide; m_wide_v = 1'b1; m_setup = 1'b1;
        m_addr = req_addr; m_lsb = req_lsb;
        m_data = req_wide ? wfn(req_addr)
               : {8'h00, (req_lsb ? wfn(req_addr)[15:8] : wfn(req_addr)[7:0])};
        naccept++;
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rsp_valid) nrsp++;
    if (rst) begin
      chk(rom_ce_n && rom_oe_n, "R1 reset pins", {rom_ce_n, rom_oe_n}, 2'b11);
      chk(!req_ready && !rsp_valid && !rom_hi_oe, "R1 reset outputs",
          {req_ready, rsp_valid, rom_hi_oe}, 3'b000);
    end else begin
      chk(req_ready == (busy == 0), pwr_phase ? "R1 ready" : "R2 ready",
          req_ready, busy == 0);
      chk(rsp_valid == (rsp_in == 0), "R4 rsp_valid", rsp_valid, rsp_in == 0);
      if (rsp_in == 0)
        chk(rsp_data == m_data, m_wide ? "R5 data" : "R6 data", rsp_data, m_data);
      chk(rom_ce_n == m_ce, pwr_phase ? "R1 ce" : (m_setup ? "R9 ce" : "R8 ce"),
          rom_ce_n, m_ce);
      chk(rom_oe_n == !(rsp_in >= 1 && rsp_in <= ACC), "R3 oe", rom_oe_n,
          !(rsp_in >= 1 && rsp_in <= ACC));
      if (rsp_in >= 1 && rsp_in <= ACC + 1) begin
        chk(rom_addr == m_addr && rom_wide == m_wide, "R3 addr",
            {rom_wide, rom_addr}, {m_wide, m_addr});
        if (m_wide)
          chk(!rom_hi_oe, "R5 shared line released", rom_hi_oe, 1'b0);
        else
          chk(rom_hi_oe && rom_hi_o == m_lsb, "R6 shared line",
              {rom_hi_oe, rom_hi_o}, {1'b1, m_lsb});
      end
      chk(!(rom_hi_oe && have_act && ($realtime - t_act < 25.0)), "R7 contention",
          rom_hi_oe, 1'b0);
    end
  end

  // ---------------- stimulus ----------------
  task automatic rd(input logic [20:0] a, input logic l, input logic w, input int junk);
    req_addr = a; req_lsb = l; req_wide = w; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    if (junk > 0) begin
      // R10: held while busy, must be ignored
      req_addr = ~a; req_wide = ~w; req_lsb = ~l;
      repeat (junk) @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    rd(21'h000123, 1'b0, 1'b1, 0);   // R1, R10: held through power wait
    rd(21'h0ABCDE, 1'b0, 1'b1, 10);  // R10 junk during busy
    rd(21'h1FFFFF, 1'b0, 1'b1, 0);   // R8 same width
    rd(21'h000000, 1'b0, 1'b1, 0);   // R8
    rd(21'h012345, 1'b0, 1'b0, 0);   // R9 to byte, R7 contention window
    rd(21'h012345, 1'b1, 1'b0, 0);   // R6 high byte
    rd(21'h1FFFFF, 1'b1, 1'b0, 5);   // R6, R10
    rd(21'h0F0F0F, 1'b0, 1'b1, 0);   // R9 back to word
    rd(21'h155555, 1'b1, 1'b0, 0);   // R9, R7
    repeat (60) @(negedge clk);
    chk(naccept == 9, "R10 accepted count", naccept, 9);
    chk(nrsp == 9, "R10 response count", nrsp, 9);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule